// File: doc/BRIEF.md
# Opcode Decoder with Pair Scrounging

This block turns one 8-bit instruction byte into the control strobes and operand fields that an execution stage needs. It sorts every byte into one of four classes: a signal strobe, a register-to-register transfer, a trap call, or a move between an accumulator and one of the first eight slots of the global or local window. For each class it extracts the fields that apply, such as the source and target register indices, the six-bit trap bank number and the get/put register, segment, direction and slot.

A scrounge stage sits between the classifier and the flow logic. It catches two transfer pairs that would be useless or too slow in hardware and turns them into different operations. A memory-to-memory copy becomes a frame close, which advances the code bank and clears the fetch offset. A literal-to-memory copy becomes a subroutine return. A transfer whose source and target name the same plain register is a no-op, and it drives no control output. The flow logic then resolves the pseudo-targets. One always jumps, one jumps on a nonzero ALU result, one jumps on a zero result, and one makes a call. Traps are calls as well. The block is purely combinational from the opcode byte and the zero flag.

Top module: `opcode_decoder`

## Requirements
- R1: `cls_o` is one-hot for every opcode. Bit 0 (signal) is set when op[7]=0 and op[3:0]=0. Bit 1 (transfer) is set when op[7]=0 and op[3:0]≠0. Bit 2 (trap) is set when op[7:6]=10. Bit 3 (get/put) is set when op[7:6]=11.
- R2: For a signal opcode, `sig_o` has exactly bit op[6:4] set when that code is enabled in `SIG_MASK`. The default mask enables codes 1..7: 1 serial-in, 2 serial-out, 3 clock-low, 4 clock-high, 5 bus-release, 6 leave frame, 7 enter frame, so opcode 0x70 strobes `sig_o[7]`. Code 0 (opcode 0x00) sets no bit.
- R3: For a transfer opcode, `src_o` = op[6:4] and `tgt_o` = op[3:0]. An ordinary pair (not scrounged, not a no-op and not a pseudo-target) asserts `move_o` and no other control output.
- R4: With scrounging enabled, opcode 0x11 (source code 1 = memory, target code 1 = memory) asserts `lid_o` only.
- R5: With scrounging enabled, opcode 0x01 (source code 0 = literal, target code 1 = memory) asserts `ret_o` only.
- R6: A transfer whose target code equals its source code, for codes 2..7, asserts no control output.
- R7: Target code 8 always asserts `jump_o`. Target code 9 asserts `jump_o` only when `zero_i`=0. Target code 10 asserts `jump_o` only when `zero_i`=1. None of these three asserts `move_o`.
- R8: Target code 11 asserts `call_o`. A trap opcode asserts both `call_o` and `trap_o`, and `bank_o` = op[5:0].
- R9: For a get/put opcode, `gp_b_o` = op[5] (1 = B), `gp_local_o` = op[4] (1 = local), `gp_put_o` = op[3] (1 = put) and `gp_slot_o` = op[2:0].
- R10: At most one of `move_o`, `jump_o`, `call_o`, `lid_o`, `ret_o` and any bit of `sig_o` is asserted for any opcode and flag value.
- R11: With `SCROUNGE_EN`=0, opcodes 0x11 and 0x01 assert `move_o` and leave `lid_o` and `ret_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Instruction byte |
| zero_i | input | 1 | ALU result is zero |
| cls_o | output | 4 | One-hot class: signal, transfer, trap, get/put |
| sig_o | output | 8 | One-hot signal strobes |
| src_o | output | 3 | Transfer source register index |
| tgt_o | output | 4 | Transfer target register index |
| move_o | output | 1 | Ordinary register copy |
| jump_o | output | 1 | Branch taken |
| call_o | output | 1 | Subroutine call (target call or trap) |
| trap_o | output | 1 | Call came from a trap opcode |
| lid_o | output | 1 | Frame close: next bank, offset 0 |
| ret_o | output | 1 | Return from subroutine |
| bank_o | output | 6 | Trap handler bank |
| gp_b_o | output | 1 | Get/put register: 0 = A, 1 = B |
| gp_local_o | output | 1 | Get/put segment: 0 = global, 1 = local |
| gp_put_o | output | 1 | Get/put direction: 0 = get, 1 = put |
| gp_slot_o | output | 3 | Get/put slot 0..7 |

## Verification
The bench builds two copies side by side on the same inputs. One uses the default parameters: scrounging on, same-register no-ops on, and signal code 0 masked off. The other is built with `SCROUNGE_EN`=0, so the scrounged opcodes 0x11 and 0x01 can be compared with their plain-move meaning in the same cycle. Together they exercise both generate branches of the scrounge stage. The full 256-opcode sweep is run against the default copy, under both values of the zero flag, to check the class and exclusivity rules.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
   localparam int OP_W     = 8;
   localparam int TGT_W    = 4;
   localparam int SRC_W    = 3;
   localparam int BANK_W   = 6;
   localparam int SLOT_W   = 3;
   localparam int SIG_N    = 1 << SRC_W;
   localparam int CLS_N    = 4;
   localparam int SRC_LSB  = TGT_W;
   localparam int CLS_SIG  = 0;
   localparam int CLS_XFER = 1;
   localparam int CLS_TRAP = 2;
   localparam int CLS_GP   = 3;
   typedef logic [SRC_W-1:0] src_t;
   typedef logic [TGT_W-1:0] tgt_t;
endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
   import opdec_pkg::*;
(
   input  logic [OP_W-1:0]   op,
   output logic [CLS_N-1:0]  cls,
   output src_t              src,
   output tgt_t              tgt,
   output logic [BANK_W-1:0] bank,
   output logic              gp_b,
   output logic              gp_local,
   output logic              gp_put,
   output logic [SLOT_W-1:0] gp_slot
);
   localparam int TOP = OP_W - 1;

   always_comb begin
      cls = '0;
      if (!op[TOP]) begin
         if (op[TGT_W-1:0] == '0) cls[CLS_SIG]  = 1'b1;
         else                     cls[CLS_XFER] = 1'b1;
      end else if (!op[TOP-1]) begin
         cls[CLS_TRAP] = 1'b1;
      end else begin
         cls[CLS_GP] = 1'b1;
      end
   end

   assign src      = op[SRC_LSB +: SRC_W];
   assign tgt      = op[TGT_W-1:0];
   assign bank     = op[BANK_W-1:0];
   assign gp_b     = op[SLOT_W+2];
   assign gp_local = op[SLOT_W+1];
   assign gp_put   = op[SLOT_W];
   assign gp_slot  = op[SLOT_W-1:0];
endmodule

// File: rtl/opdec_scrounge.sv
module opdec_scrounge
   import opdec_pkg::*;
#(
   parameter bit   SCROUNGE_EN = 1'b1,
   parameter bit   NOP_SAME_EN = 1'b1,
   parameter src_t SRC_LIT     = 3'd0,
   parameter src_t SRC_MEM     = 3'd1,
   parameter tgt_t TGT_MEM     = 4'd1
) (
   input  logic is_xfer,
   input  src_t src,
   input  tgt_t tgt,
   output logic lid,
   output logic ret,
   output logic plain
);
   logic same;

   assign same = NOP_SAME_EN && (tgt == tgt_t'(src))
                 && (src != SRC_MEM) && (src != SRC_LIT);

   generate
      if (SCROUNGE_EN) begin : g_scr
         assign lid = is_xfer && (src == SRC_MEM) && (tgt == TGT_MEM);
         assign ret = is_xfer && (src == SRC_LIT) && (tgt == TGT_MEM);
      end else begin : g_raw
         assign lid = 1'b0;
         assign ret = 1'b0;
      end
   endgenerate

   assign plain = is_xfer && !lid && !ret && !same;
endmodule

// File: rtl/opdec_flow.sv
module opdec_flow
   import opdec_pkg::*;
#(
   parameter tgt_t TGT_JMP  = 4'd8,
   parameter tgt_t TGT_JNZ  = 4'd9,
   parameter tgt_t TGT_JZ   = 4'd10,
   parameter tgt_t TGT_CALL = 4'd11
) (
   input  logic plain,
   input  logic is_trap,
   input  logic zero,
   input  tgt_t tgt,
   output logic move,
   output logic jump,
   output logic call
);
   always_comb begin
      move = 1'b0;
      jump = 1'b0;
      call = is_trap;
      if (plain) begin
         if (tgt == TGT_JMP)       jump = 1'b1;
         else if (tgt == TGT_JNZ)  jump = !zero;
         else if (tgt == TGT_JZ)   jump = zero;
         else if (tgt == TGT_CALL) call = 1'b1;
         else                      move = 1'b1;
      end
   end
endmodule

// File: rtl/opcode_decoder.sv
module opcode_decoder
   import opdec_pkg::*;
#(
   parameter bit         SCROUNGE_EN = 1'b1,
   parameter bit         NOP_SAME_EN = 1'b1,
   parameter logic [7:0] SIG_MASK    = 8'hFE,
   parameter src_t       SRC_LIT     = 3'd0,
   parameter src_t       SRC_MEM     = 3'd1,
   parameter tgt_t       TGT_MEM     = 4'd1,
   parameter tgt_t       TGT_JMP     = 4'd8,
   parameter tgt_t       TGT_JNZ     = 4'd9,
   parameter tgt_t       TGT_JZ      = 4'd10,
   parameter tgt_t       TGT_CALL    = 4'd11
) (
   input  logic [7:0] op_i,
   input  logic       zero_i,
   output logic [3:0] cls_o,
   output logic [7:0] sig_o,
   output logic [2:0] src_o,
   output logic [3:0] tgt_o,
   output logic       move_o,
   output logic       jump_o,
   output logic       call_o,
   output logic       trap_o,
   output logic       lid_o,
   output logic       ret_o,
   output logic [5:0] bank_o,
   output logic       gp_b_o,
   output logic       gp_local_o,
   output logic       gp_put_o,
   output logic [2:0] gp_slot_o
);
   generate
      if (TGT_JMP == TGT_JNZ || TGT_JMP == TGT_JZ || TGT_JMP == TGT_CALL ||
          TGT_JNZ == TGT_JZ || TGT_JNZ == TGT_CALL || TGT_JZ == TGT_CALL) begin : g_bad_flow
         $error("pseudo-target codes must differ");
      end
      if (TGT_MEM == '0 || TGT_JMP == '0 || TGT_JNZ == '0 || TGT_JZ == '0 ||
          TGT_CALL == '0 || TGT_MEM == TGT_JMP || TGT_MEM == TGT_CALL) begin : g_bad_tgt
         $error("target code zero is reserved for signals; memory code must be unique");
      end
      if (SRC_LIT == SRC_MEM) begin : g_bad_src
         $error("literal and memory source codes must differ");
      end
   endgenerate

   src_t src;
   tgt_t tgt;
   logic plain;

   opdec_fields u_fields (
      .op       (op_i),
      .cls      (cls_o),
      .src      (src),
      .tgt      (tgt),
      .bank     (bank_o),
      .gp_b     (gp_b_o),
      .gp_local (gp_local_o),
      .gp_put   (gp_put_o),
      .gp_slot  (gp_slot_o)
   );

   opdec_scrounge #(
      .SCROUNGE_EN (SCROUNGE_EN),
      .NOP_SAME_EN (NOP_SAME_EN),
      .SRC_LIT     (SRC_LIT),
      .SRC_MEM     (SRC_MEM),
      .TGT_MEM     (TGT_MEM)
   ) u_scrounge (
      .is_xfer (cls_o[CLS_XFER]),
      .src     (src),
      .tgt     (tgt),
      .lid     (lid_o),
      .ret     (ret_o),
      .plain   (plain)
   );

   opdec_flow #(
      .TGT_JMP  (TGT_JMP),
      .TGT_JNZ  (TGT_JNZ),
      .TGT_JZ   (TGT_JZ),
      .TGT_CALL (TGT_CALL)
   ) u_flow (
      .plain   (plain),
      .is_trap (cls_o[CLS_TRAP]),
      .zero    (zero_i),
      .tgt     (tgt),
      .move    (move_o),
      .jump    (jump_o),
      .call    (call_o)
   );

   generate
      for (genvar i = 0; i < SIG_N; i++) begin : g_sig
         assign sig_o[i] = SIG_MASK[i] && cls_o[CLS_SIG] && (src == src_t'(i));
      end
   endgenerate

   assign src_o  = src;
   assign tgt_o  = tgt;
   assign trap_o = cls_o[CLS_TRAP];

   always_comb begin
      assert_class_onehot_R1: assert ($onehot(cls_o));
      assert_sig_in_class_R2: assert (!(|sig_o) || cls_o[CLS_SIG]);
      assert_scrounge_xfer_R4: assert (!(lid_o || ret_o) || cls_o[CLS_XFER]);
      assert_jump_xfer_R7: assert (!jump_o || cls_o[CLS_XFER]);
      assert_trap_calls_R8: assert (!trap_o || call_o);
      assert_single_ctrl_R10: assert ($onehot0({move_o, jump_o, call_o, lid_o, ret_o, |sig_o}));
   end
endmodule

// File: tb/opcode_decoder_tb.sv
module opcode_decoder_tb;
   logic       clk = 1'b0;
   logic [7:0] op = 8'h00;
   logic       zero = 1'b0;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   logic [3:0] cls_o;
   logic [7:0] sig_o;
   logic [2:0] src_o;
   logic [3:0] tgt_o;
   logic       move_o, jump_o, call_o, trap_o, lid_o, ret_o;
   logic [5:0] bank_o;
   logic       gp_b_o, gp_local_o, gp_put_o;
   logic [2:0] gp_slot_o;

   logic [3:0] r_cls;
   logic [7:0] r_sig;
   logic [2:0] r_src;
   logic [3:0] r_tgt;
   logic       r_move, r_jump, r_call, r_trap, r_lid, r_ret;
   logic [5:0] r_bank;
   logic       r_gb, r_gl, r_gp;
   logic [2:0] r_gs;

   opcode_decoder u_dut (
      .op_i(op), .zero_i(zero), .cls_o(cls_o), .sig_o(sig_o), .src_o(src_o),
      .tgt_o(tgt_o), .move_o(move_o), .jump_o(jump_o), .call_o(call_o),
      .trap_o(trap_o), .lid_o(lid_o), .ret_o(ret_o), .bank_o(bank_o),
      .gp_b_o(gp_b_o), .gp_local_o(gp_local_o), .gp_put_o(gp_put_o),
      .gp_slot_o(gp_slot_o)
   );

   opcode_decoder #(.SCROUNGE_EN(1'b0)) u_dut_raw (
      .op_i(op), .zero_i(zero), .cls_o(r_cls), .sig_o(r_sig), .src_o(r_src),
      .tgt_o(r_tgt), .move_o(r_move), .jump_o(r_jump), .call_o(r_call),
      .trap_o(r_trap), .lid_o(r_lid), .ret_o(r_ret), .bank_o(r_bank),
      .gp_b_o(r_gb), .gp_local_o(r_gl), .gp_put_o(r_gp), .gp_slot_o(r_gs)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s op=%02h zero=%0b actual=%0h expected=%0h", req, op, zero, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] o, input logic z);
      @(posedge clk);
      op   = o;
      zero = z;
      @(negedge clk);
   endtask

   function automatic logic [5:0] ctrl();
      return {move_o, jump_o, call_o, lid_o, ret_o, |sig_o};
   endfunction

   task automatic t_idle();
      apply(8'h00, 1'b0);
      chk(cls_o == 4'b0001, "R1", cls_o, 4'b0001);
      chk(sig_o == 8'h00, "R2", sig_o, 8'h00);
      chk(ctrl() == 6'd0, "R10", ctrl(), 0);
   endtask

   task automatic t_signals();
      for (int c = 1; c < 8; c++) begin
         apply(8'(c << 4), 1'b0);
         chk(sig_o == 8'(1 << c), "R2", sig_o, 8'(1 << c));
         chk({move_o, jump_o, call_o, lid_o, ret_o} == 5'd0, "R2", ctrl(), 1);
      end
      apply(8'd112, 1'b1);
      chk(sig_o == 8'h80, "R2", sig_o, 8'h80);
   endtask

   task automatic t_sweep();
      for (int z = 0; z < 2; z++) begin
         for (int o = 0; o < 256; o++) begin
            logic [3:0] e;
            logic [7:0] b;
            b = 8'(o);
            if (!b[7]) e = (b[3:0] == 4'd0) ? 4'b0001 : 4'b0010;
            else       e = b[6] ? 4'b1000 : 4'b0100;
            apply(b, z[0]);
            chk(cls_o == e, "R1", cls_o, e);
            chk($countones(ctrl()) <= 1, "R10", ctrl(), 0);
         end
      end
   endtask

   task automatic t_xfer();
      apply(8'h23, 1'b0);
      chk(src_o == 3'd2 && tgt_o == 4'd3, "R3", {src_o, tgt_o}, {3'd2, 4'd3});
      chk(ctrl() == 6'b100000, "R3", ctrl(), 6'b100000);
      apply(8'h7F, 1'b1);
      chk(src_o == 3'd7 && tgt_o == 4'd15, "R3", {src_o, tgt_o}, {3'd7, 4'd15});
      chk(ctrl() == 6'b100000, "R3", ctrl(), 6'b100000);
   endtask

   task automatic t_scrounge();
      apply(8'h11, 1'b0);
      chk(ctrl() == 6'b000100, "R4", ctrl(), 6'b000100);
      chk(r_move && !r_lid && !r_ret, "R11", {r_move, r_lid, r_ret}, 3'b100);
      apply(8'h01, 1'b1);
      chk(ctrl() == 6'b000010, "R5", ctrl(), 6'b000010);
      chk(r_move && !r_lid && !r_ret, "R11", {r_move, r_lid, r_ret}, 3'b100);
   endtask

   task automatic t_nop();
      for (int c = 2; c < 8; c++) begin
         apply(8'((c << 4) | c), 1'b0);
         chk(ctrl() == 6'd0, "R6", ctrl(), 0);
      end
   endtask

   task automatic t_jump();
      for (int z = 0; z < 2; z++) begin
         apply(8'h38, z[0]);
         chk(ctrl() == 6'b010000, "R7", ctrl(), 6'b010000);
         apply(8'h39, z[0]);
         chk(jump_o == !z[0] && !move_o, "R7", jump_o, !z[0]);
         apply(8'h3A, z[0]);
         chk(jump_o == z[0] && !move_o, "R7", jump_o, z[0]);
      end
   endtask

   task automatic t_call();
      apply(8'h4B, 1'b0);
      chk(ctrl() == 6'b001000 && !trap_o, "R8", {ctrl(), trap_o}, 7'b0010000);
      apply(8'hAD, 1'b1);
      chk(call_o && trap_o && !move_o && !jump_o, "R8", {call_o, trap_o}, 2'b11);
      chk(bank_o == 6'h2D, "R8", bank_o, 6'h2D);
      apply(8'h80, 1'b0);
      chk(bank_o == 6'h00 && call_o, "R8", bank_o, 0);
   endtask

   task automatic t_getput();
      apply(8'hED, 1'b0);
      chk({gp_b_o, gp_local_o, gp_put_o, gp_slot_o} == {3'b101, 3'd5}, "R9",
          {gp_b_o, gp_local_o, gp_put_o, gp_slot_o}, {3'b101, 3'd5});
      chk(ctrl() == 6'd0, "R9", ctrl(), 0);
      apply(8'hD2, 1'b1);
      chk({gp_b_o, gp_local_o, gp_put_o, gp_slot_o} == {3'b010, 3'd2}, "R9",
          {gp_b_o, gp_local_o, gp_put_o, gp_slot_o}, {3'b010, 3'd2});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_idle();
      t_signals();
      t_xfer();
      t_scrounge();
      t_nop();
      t_jump();
      t_call();
      t_getput();
      t_sweep();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end
endmodule